// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block holds the per-pin control state of a 16-pin bidirectional port, arranged as two 8-bit ports (port 0 on pins 7:0, port 1 on pins 15:8). A simple synchronous register bus reads and writes the block through an address, write data, a write strobe, a read strobe and registered read data. Each port has three writable registers: a latch for the levels driven out, a per-pin polarity-inversion mask, and a per-pin direction mask. Each port also has a read-only input register.

The block drives an output value and an output enable for every pin, and the pad drivers outside it use them. Incoming pin levels pass through a synchronizer. The polarity mask then acts only on the value reported in the input register. Reading an output register returns the latched value, not the level on the pin. A serial-bus front end sits in front of the register bus and turns its transactions into single register accesses.

Top module: `gpx_regbank`

## Requirements
- R1: While reset is held and just after it, every output register reads FFh, every polarity register reads 00h, every direction register reads FFh, `pin_oe` is 0000h, `pin_out` is 0000h and `bus_rdata` is 00h.
- R2: The address map is input 00h/01h, output 02h/03h, polarity 04h/05h and direction 06h/07h. An even address selects port 0 (pins 7:0) and an odd address selects port 1 (pins 15:8).
- R3: A direction bit of 1 makes its pin an input, with `pin_oe` low. A direction bit of 0 makes it an output, with `pin_oe` high.
- R4: For an output pin, `pin_out` equals the matching output register bit. For an input pin, `pin_out` is 0 whatever the output register holds.
- R5: Reading an output register returns the value last written to it, not the pin level. This holds even while the pin is an input.
- R6: The input register bit equals the synchronized pin level XOR the matching polarity bit (1 inverts, 0 passes through).
- R7: Pin levels pass through two flops before they reach the input register. A read strobe sampled on the second clock edge after a pin change still returns the old level. A read strobe sampled on the third edge returns the new level.
- R8: The input registers are read-only. A write to 00h or 01h changes no register and no output.
- R9: A read from any address of 08h or above returns 00h. A write to such an address has no effect.
- R10: A write takes effect on the clock edge where `bus_wr` is high. `bus_rdata` loads on the edge where `bus_rd` is high and holds while `bus_rd` is low. When a read and a write to the same address fall in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Levels to drive on output pins |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
The checker watches five things on every cycle. It confirms that no input pin ever carries a driven level. It confirms that writes to the direction and output registers of port 0 show up at the pins on the next cycle. It confirms that read-only and unmapped writes leave the pins untouched, that unmapped reads return zero, and that read data holds between strobes. The bench scenarios cover what a property over ports cannot see. These are the reset values and the address map seen through reads, the polarity effect on input reads, and the exact two-flop latency after a pin change. They also cover the old-value result of a read that coincides with a write to the same register.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 2;
    localparam int PIN_W     = PORT_W * NUM_PORTS;

    // register kind selected by address bits [2:1]
    typedef enum logic [1:0] {
        RK_INPUT  = 2'd0,
        RK_OUTPUT = 2'd1,
        RK_POLAR  = 2'd2,
        RK_DIR    = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic      port;
    } reg_sel_t;

endpackage

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    always_comb begin
        sel.hit  = (addr[ADDR_W-1:3] == '0);
        sel.kind = reg_kind_e'(addr[2:1]);
        sel.port = addr[0];
    end

endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] in_val,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    localparam int LAST = SYNC - 1;

    logic [W-1:0] sync_q [SYNC];

    // synchronizer chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= pin_in;
            for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            unique case (kind)
                RK_OUTPUT: out_q <= wdata;
                RK_POLAR:  pol_q <= wdata;
                RK_DIR:    dir_q <= wdata;
                RK_INPUT:  ;
            endcase
        end
    end

    always_comb begin
        in_val  = sync_q[LAST] ^ pol_q;
        pin_oe  = ~dir_q;
        pin_out = out_q & ~dir_q;
    end

endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
    import gpx_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [15:0]       pin_in,
    output logic [15:0]       pin_out,
    output logic [15:0]       pin_oe
);

    reg_sel_t          sel;
    logic [PORT_W-1:0] out_a [NUM_PORTS];
    logic [PORT_W-1:0] pol_a [NUM_PORTS];
    logic [PORT_W-1:0] dir_a [NUM_PORTS];
    logic [PORT_W-1:0] in_a  [NUM_PORTS];
    logic [PORT_W-1:0] rd_next;

    gpx_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_here;
        assign wr_here = bus_wr && sel.hit && (sel.port == 1'(p));

        gpx_port #(.W(PORT_W), .SYNC(SYNC_STAGES)) i_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_here),
            .kind    (sel.kind),
            .wdata   (bus_wdata),
            .pin_in  (pin_in[p*PORT_W +: PORT_W]),
            .out_q   (out_a[p]),
            .pol_q   (pol_a[p]),
            .dir_q   (dir_a[p]),
            .in_val  (in_a[p]),
            .pin_out (pin_out[p*PORT_W +: PORT_W]),
            .pin_oe  (pin_oe[p*PORT_W +: PORT_W])
        );
    end

    always_comb begin
        rd_next = '0;
        if (sel.hit) begin
            unique case (sel.kind)
                RK_INPUT:  rd_next = in_a[sel.port];
                RK_OUTPUT: rd_next = out_a[sel.port];
                RK_POLAR:  rd_next = pol_a[sel.port];
                RK_DIR:    rd_next = dir_a[sel.port];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

endmodule

// File: rtl/gpx_regbank_chk.sv
module gpx_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [15:0]       pin_out,
    input logic [15:0]       pin_oe
);

    // R4
    in_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == 16'h0000);

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(6)) |=> (pin_oe[7:0] == ~$past(bus_wdata)));

    // R4
    out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(2)) |=> (pin_out[7:0] == ($past(bus_wdata) & pin_oe[7:0])));

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr < ADDR_W'(2)) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R9
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= ADDR_W'(8)) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R9
    hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= ADDR_W'(8)) |=> (bus_rdata == 8'h00));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpx_regbank gpx_regbank_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_gpx_regbank.sv
module test_gpx_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in = 16'hA53C;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpx_regbank i_gpx_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {is_read, address, data-or-expected}; pins held at A53Ch
    localparam int NV = 24;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 8'h00, 8'h3C}, // R6 R2 port0 input, no inversion
        {1'b1, 8'h01, 8'hA5}, // R6 R2 port1 input
        {1'b1, 8'h02, 8'hFF}, // R1 output default
        {1'b1, 8'h03, 8'hFF}, // R1
        {1'b1, 8'h04, 8'h00}, // R1 polarity default
        {1'b1, 8'h05, 8'h00}, // R1
        {1'b1, 8'h06, 8'hFF}, // R1 direction default
        {1'b1, 8'h07, 8'hFF}, // R1
        {1'b0, 8'h04, 8'hF0},
        {1'b1, 8'h00, 8'hCC}, // R6 inverted upper nibble
        {1'b0, 8'h05, 8'h0F},
        {1'b1, 8'h01, 8'hAA}, // R6
        {1'b0, 8'h02, 8'h5A},
        {1'b1, 8'h02, 8'h5A}, // R5 latched while input
        {1'b0, 8'h00, 8'h12},
        {1'b1, 8'h00, 8'hCC}, // R8 write ignored
        {1'b0, 8'h09, 8'h77},
        {1'b1, 8'h09, 8'h00}, // R9
        {1'b1, 8'h08, 8'h00}, // R9
        {1'b1, 8'hFF, 8'h00}, // R9
        {1'b0, 8'h06, 8'h0F},
        {1'b1, 8'h06, 8'h0F}, // R3 R2
        {1'b0, 8'h03, 8'hC3},
        {1'b0, 8'h07, 8'h00}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        chk("R1 oe in reset", pin_oe, 16'h0000);
        chk("R1 out in reset", pin_out, 16'h0000);
        chk("R1 rdata in reset", {8'h00, bus_rdata}, 16'h0000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 oe after reset", pin_oe, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][16]) begin
                bus_read(VEC[i][15:8], rd);
                chk($sformatf("R2 vector %0d read %h", i, VEC[i][15:8]), {8'h00, rd}, {8'h00, VEC[i][7:0]});
            end else begin
                bus_write(VEC[i][15:8], VEC[i][7:0]);
            end
        end

        // dir0=0F, out0=5A, dir1=00, out1=C3
        @(negedge clk);
        chk("R3 oe", pin_oe, 16'hFFF0);
        chk("R4 out gated", pin_out, 16'hC350);
        bus_read(8'h03, rd);
        chk("R5 out1 readback", {8'h00, rd}, 16'h00C3);

        // R7 two-flop latency; pol0=F0, old pin0=3C -> CC, new pin0=00 -> F0
        @(negedge clk);
        pin_in[7:0] = 8'h00;
        bus_addr = 8'h00; bus_rd = 1'b1;
        @(negedge clk);
        chk("R7 edge1 old", {8'h00, bus_rdata}, 16'h00CC);
        @(negedge clk);
        chk("R7 edge2 old", {8'h00, bus_rdata}, 16'h00CC);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R7 edge3 new", {8'h00, bus_rdata}, 16'h00F0);
        pin_in[7:0] = 8'hFF;
        repeat (4) @(negedge clk);
        chk("R10 rdata holds", {8'h00, bus_rdata}, 16'h00F0);

        // R10 read and write same address in one cycle
        @(negedge clk);
        bus_addr = 8'h02; bus_wdata = 8'hAA; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R10 read before write", {8'h00, bus_rdata}, 16'h005A);
        bus_read(8'h02, rd);
        chk("R10 write landed", {8'h00, rd}, 16'h00AA);
        chk("R4 out after write", pin_out, 16'hC3A0);

        // R8 write to port1 input leaves pins unchanged
        bus_write(8'h01, 8'h00);
        chk("R8 pins unchanged", pin_oe, 16'hFFF0);

        finish_run();
    end

endmodule